// File: doc/BRIEF.md
# Ping-Pong Sound Sample Fetcher

This block streams audio sample bytes from memory to a sample sink. Software programs two buffer descriptors, called A and B. Each descriptor holds a current address and an end address. The engine reads memory in fixed bursts of 16 bytes and places them in a two-burst FIFO. It releases one byte on the sample strobe at each sample period, which is `SAMPLE_CYCLES` clocks; the default is 10 µs at 100 MHz.

When the active buffer's pointer reaches its end address, the engine does two things. It sets the interrupt flag, and it moves to the other descriptor so that software can refill the drained one. If the other descriptor holds no valid buffer, the overrun flag is set as well. Setting a stop bit in B's end value marks B as the last buffer. Software treats the state where both status bits are set as "playback done".

The interrupt is raised when the last burst of a buffer has been fetched, not when it has been played. Up to one FIFO's worth of bytes is therefore still queued at that moment. As a result, a 1024-byte buffer reports completion slightly before 1024 sample periods have passed.

Top module: `snd_dma`

## Requirements
- R1: After reset, `stat_o` is 0, `mem_req_o` is low and `smp_valid_o` is low.
- R2: A write to register 0 (control) starts the engine only when bit 5 (enable) is 1 and bits [4:0] equal 16. Any other size value leaves the engine idle, and no memory request is made.
- R3: Each request shows the active descriptor's current address. The request is held stable until `mem_gnt_i`. Each completed 16-beat burst advances that address by 16.
- R4: Bytes leave on `smp_valid_o`/`smp_data_o` in the order they were fetched, at most one per `SAMPLE_CYCLES` clocks. Successive strobes are spaced by a whole multiple of that period.
- R5: Registers 1 and 2 hold A's current and end address; registers 3 and 4 hold B's. Writing an end register makes that descriptor valid. When the active buffer's next address reaches or passes its end, the engine sets the interrupt flag (`stat_o[0]`). If the other descriptor is valid, fetching continues from it.
- R6: If the other descriptor is not valid at that switch, the overrun flag (`stat_o[1]`) is set, and it stays set until a clear. Fetching stalls until the descriptor that is now active is made valid, and then it resumes there.
- R7: Bit 31 of a write to B's end register marks B as final. After a final B drains, both status bits are 1 and no further request is issued, even if A is valid. Bit 31 of a write to A's end register is ignored.
- R8: Any write to registers 1 to 4 clears the interrupt flag. Reading `stat_o` has no effect on it.
- R9: When the interrupt flag rises, between 1 and the FIFO depth (32) of the buffer's bytes are still waiting to be played.
- R10: A control write with enable 0 flushes the FIFO. No further samples are strobed and no new request is issued.
- R11: A control write with bit 7 (clear) set zeroes both flags, disables the engine and invalidates both descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select: 0 control, 1/2 A current/end, 3/4 B current/end |
| reg_wdata_i | input | 32 | Register write data |
| stat_o | output | 2 | Bit 0 interrupt, bit 1 overrun |
| mem_req_o | output | 1 | Burst read request |
| mem_addr_o | output | ADDR_W | Burst start address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data beat valid |
| mem_rdata_i | input | 8 | Read data byte |
| smp_valid_o | output | 1 | Sample strobe |
| smp_data_o | output | 8 | Sample byte |

## Verification
The bench memory returns an address-derived byte pattern, so any dropped, repeated or misplaced byte shows up as a data mismatch at the sample output. Four buffer arrangements are tried:
- A followed by a valid B, which separates a correct switch from a stall.
- B draining with no valid A, which exposes overrun, the stall and the resume after a late refill.
- Both end values carrying the stop bit, which separates B's final marking from the stop bit ignored on A.
- A long buffer cut short by disable, which shows whether the flush really silences fetch and output.

A wrong burst-size field and a clear followed by a bare enable check that the engine does not start when it should not.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_A_CUR = 3'd1;
  localparam logic [2:0] RA_A_END = 3'd2;
  localparam logic [2:0] RA_B_CUR = 3'd3;
  localparam logic [2:0] RA_B_END = 3'd4;

  localparam int CTRL_CLR  = 7;
  localparam int CTRL_EN   = 5;
  localparam int SIZE_W    = 5;
  localparam int STOP_BIT  = 31;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_DATA} fetch_st_e;
endpackage

// File: rtl/snd_dma_regs.sv
module snd_dma_regs import snd_dma_pkg::*; #(
  parameter int ADDR_W      = 24,
  parameter int BURST_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              burst_done_i,
  output logic              en_o,
  output logic              flush_o,
  output logic              fetch_ok_o,
  output logic [ADDR_W-1:0] act_addr_o,
  output logic [1:0]        stat_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

  logic [ADDR_W-1:0] cur_q [2];
  logic [ADDR_W-1:0] end_q [2];
  logic [1:0]        vld_q;
  logic              stop_q, act_q, halt_q, en_q, irq_q, ovr_q;

  logic ctrl_wr, clr_wr, en_req, desc_wr, oth, fin;
  logic [1:0] wr_end;
  logic [ADDR_W-1:0] nxt;

  assign ctrl_wr   = we_i && (addr_i == RA_CTRL);
  assign clr_wr    = ctrl_wr && wdata_i[CTRL_CLR];
  assign en_req    = wdata_i[CTRL_EN] && (wdata_i[SIZE_W-1:0] == SIZE_W'(BURST_BYTES));
  assign flush_o   = ctrl_wr && (wdata_i[CTRL_CLR] || !en_req);
  assign desc_wr   = we_i && (addr_i >= RA_A_CUR) && (addr_i <= RA_B_END);
  assign wr_end[0] = we_i && (addr_i == RA_A_END);
  assign wr_end[1] = we_i && (addr_i == RA_B_END);
  assign oth       = ~act_q;
  assign nxt       = cur_q[act_q] + STEP;
  assign fin       = burst_done_i && (nxt >= end_q[act_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 2; i++) begin
        cur_q[i] <= '0;
        end_q[i] <= '0;
      end
      vld_q <= '0; stop_q <= 1'b0; act_q <= 1'b0; halt_q <= 1'b0;
      en_q <= 1'b0; irq_q <= 1'b0; ovr_q <= 1'b0;
    end else if (clr_wr) begin
      for (int i = 0; i < 2; i++) begin
        cur_q[i] <= '0;
        end_q[i] <= '0;
      end
      vld_q <= '0; stop_q <= 1'b0; act_q <= 1'b0; halt_q <= 1'b0;
      en_q <= 1'b0; irq_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      if (ctrl_wr) en_q <= en_req;
      if (we_i && addr_i == RA_A_CUR) cur_q[0] <= wdata_i[ADDR_W-1:0];
      if (we_i && addr_i == RA_B_CUR) cur_q[1] <= wdata_i[ADDR_W-1:0];
      if (wr_end[0]) begin
        end_q[0] <= wdata_i[ADDR_W-1:0];
        vld_q[0] <= 1'b1;
      end
      if (wr_end[1]) begin
        end_q[1] <= wdata_i[ADDR_W-1:0];
        vld_q[1] <= 1'b1;
        stop_q   <= wdata_i[STOP_BIT];
      end
      if (desc_wr) irq_q <= 1'b0;
      // completion update wins over a same-cycle descriptor write
      if (burst_done_i) begin
        cur_q[act_q] <= nxt;
        if (fin) begin
          vld_q[act_q] <= 1'b0;
          irq_q        <= 1'b1;
          if (act_q && stop_q) begin
            halt_q <= 1'b1;
            ovr_q  <= 1'b1;
          end else begin
            act_q <= oth;
            if (!(vld_q[oth] || wr_end[oth])) ovr_q <= 1'b1;
          end
        end
      end
    end
  end

  assign en_o       = en_q;
  assign fetch_ok_o = en_q && vld_q[act_q] && !halt_q;
  assign act_addr_o = cur_q[act_q];
  assign stat_o     = {ovr_q, irq_q};

  AST_CLR_EMPTIES_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (stat_o == 2'b00)); // R11
  AST_DESC_WR_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_wr && !burst_done_i && !clr_wr) |=> !stat_o[0]); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[1] && !clr_wr) |=> stat_o[1]); // R6
  AST_FINAL_B_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && act_q && stop_q && !clr_wr) |=> (stat_o == 2'b11)); // R7
endmodule

// File: rtl/snd_dma_fetch.sv
module snd_dma_fetch import snd_dma_pkg::*; #(
  parameter int ADDR_W      = 24,
  parameter int BURST_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ok_i,
  input  logic              room_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              gnt_i,
  input  logic              rvalid_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              push_o,
  output logic              done_o
);
  localparam int BW = $clog2(BURST_BYTES);

  fetch_st_e         st_q;
  logic [BW-1:0]     beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic              drop_q, last;

  assign last = (beat_q == BW'(BURST_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= F_IDLE; beat_q <= '0; addr_q <= '0; drop_q <= 1'b0;
    end else begin
      unique case (st_q)
        F_IDLE: if (ok_i && room_i && !flush_i) begin
          st_q   <= F_REQ;
          addr_q <= addr_i;
        end
        F_REQ: if (gnt_i) begin
          st_q   <= F_DATA;
          beat_q <= '0;
          drop_q <= flush_i;
        end else if (flush_i) begin
          st_q <= F_IDLE;
        end
        F_DATA: begin
          // a granted burst is always drained, but its bytes are dropped after a flush
          if (flush_i) drop_q <= 1'b1;
          if (rvalid_i) begin
            beat_q <= beat_q + 1'b1;
            if (last) st_q <= F_IDLE;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign req_o  = (st_q == F_REQ);
  assign addr_o = addr_q;
  assign push_o = (st_q == F_DATA) && rvalid_i && !drop_q && !flush_i;
  assign done_o = push_o && last;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && !flush_i) |=> req_o); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && !flush_i) |=> $stable(addr_o)); // R3
  AST_NO_REQ_AFTER_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !req_o); // R10
endmodule

// File: rtl/snd_dma_fifo.sv
module snd_dma_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [W-1:0]               wdata_i,
  input  logic                       pop_i,
  output logic [W-1:0]               rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && !flush_i;
  assign do_pop  = pop_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i) |-> (cnt_q < CW'(DEPTH))); // R4
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0)); // R4
endmodule

// File: rtl/snd_dma_pacer.sv
module snd_dma_pacer #(
  parameter int PERIOD = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       flush_i,
  input  logic       empty_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       smp_valid_o,
  output logic [7:0] smp_data_o
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;
  logic          tick, vld_q;
  logic [7:0]    dat_q;

  assign tick  = en_i && !flush_i && (cnt_q == CW'(PERIOD - 1));
  assign pop_o = tick && !empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; vld_q <= 1'b0; dat_q <= '0;
    end else begin
      if (!en_i || flush_i || tick) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
      vld_q <= pop_o;
      if (pop_o) dat_q <= data_i;
    end
  end

  assign smp_valid_o = vld_q;
  assign smp_data_o  = dat_q;

  AST_STROBE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o); // R4
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !smp_valid_o); // R10
endmodule

// File: rtl/snd_dma.sv
module snd_dma import snd_dma_pkg::*; #(
  parameter int ADDR_W        = 24,
  parameter int BURST_BYTES   = 16,
  parameter int FIFO_BURSTS   = 2,
  parameter int SAMPLE_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [1:0]        stat_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              smp_valid_o,
  output logic [7:0]        smp_data_o
);
  localparam int DEPTH = BURST_BYTES * FIFO_BURSTS;
  localparam int CW    = $clog2(DEPTH + 1);

  logic              en, flush, ok, room, push, done, pop;
  logic [ADDR_W-1:0] act_addr;
  logic [7:0]        head;
  logic [CW-1:0]     cnt;

  assign room = (cnt <= CW'(DEPTH - BURST_BYTES));

  snd_dma_regs #(.ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .burst_done_i(done), .en_o(en), .flush_o(flush), .fetch_ok_o(ok),
    .act_addr_o(act_addr), .stat_o(stat_o)
  );

  snd_dma_fetch #(.ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)) u_fetch (
    .clk_i, .rst_ni, .ok_i(ok), .room_i(room), .flush_i(flush), .addr_i(act_addr),
    .gnt_i(mem_gnt_i), .rvalid_i(mem_rvalid_i), .req_o(mem_req_o),
    .addr_o(mem_addr_o), .push_o(push), .done_o(done)
  );

  snd_dma_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(push), .wdata_i(mem_rdata_i),
    .pop_i(pop), .rdata_o(head), .cnt_o(cnt)
  );

  snd_dma_pacer #(.PERIOD(SAMPLE_CYCLES)) u_pacer (
    .clk_i, .rst_ni, .en_i(en), .flush_i(flush), .empty_i(cnt == '0),
    .data_i(head), .pop_o(pop), .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o)
  );

  AST_FETCH_NEEDS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (cnt <= CW'(DEPTH - BURST_BYTES))); // R3
endmodule

// File: tb/sim_snd_dma.sv
module sim_snd_dma;
  localparam int AW = 16, BB = 16, FB = 2, SC = 8, DEPTH = BB * FB;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        gnt = 1'b0, rvalid = 1'b0;
  logic [7:0]  rdata = '0;
  logic [1:0]  stat;
  logic        mem_req, smp_valid;
  logic [AW-1:0] mem_addr;
  logic [7:0]  smp_data;

  snd_dma #(.ADDR_W(AW), .BURST_BYTES(BB), .FIFO_BURSTS(FB), .SAMPLE_CYCLES(SC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .stat_o(stat), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_gnt_i(gnt), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .smp_valid_o(smp_valid), .smp_data_o(smp_data)
  );

  int nchk = 0, nerr = 0, cyc = 0, req_cnt = 0, smp_cnt = 0, last_cyc = 0;
  bit last_ok = 1'b0, prev_irq = 1'b0, finished = 1'b0;
  logic [7:0] exp_q[$];

  // behavioural descriptor model
  logic [AW-1:0] m_cur[2], m_end[2];
  bit m_vld[2], m_stop, m_act, m_halt;

  function automatic logic [7:0] pat(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin
      m_cur[i] = '0; m_end[i] = '0; m_vld[i] = 1'b0;
    end
    m_stop = 1'b0; m_act = 1'b0; m_halt = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      3'd0: begin
        last_ok = 1'b0;
        if (d[7]) m_reset();
      end
      3'd1: m_cur[0] = d[AW-1:0];
      3'd2: begin m_end[0] = d[AW-1:0]; m_vld[0] = 1'b1; end
      3'd3: m_cur[1] = d[AW-1:0];
      3'd4: begin m_end[1] = d[AW-1:0]; m_vld[1] = 1'b1; m_stop = d[31]; end
      default: ;
    endcase
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_stat(input logic [1:0] want, input string tag);
    int n = 0;
    while (stat != want && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(stat == want, tag, stat, want);
  endtask

  task automatic wait_drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  // memory responder; also checks every request against the descriptor model
  initial begin
    logic [AW-1:0] a;
    m_reset();
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        a = mem_addr;
        req_cnt++;
        chk(m_vld[m_act] && !m_halt, "R3 request only from a valid active buffer", 1, 0);
        chk(a == m_cur[m_act], "R3 R5 request address", a, m_cur[m_act]);
        for (int i = 0; i < BB; i++) exp_q.push_back(pat(a + AW'(i)));
        m_cur[m_act] = m_cur[m_act] + AW'(BB);
        if (m_cur[m_act] >= m_end[m_act]) begin
          m_vld[m_act] = 1'b0;
          if (m_act && m_stop) m_halt = 1'b1;
          else m_act = ~m_act;
        end
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        for (int i = 0; i < BB; i++) begin
          rvalid = 1'b1;
          rdata = pat(a + AW'(i));
          @(negedge clk);
        end
        rvalid = 1'b0;
      end
    end
  end

  // sample monitor, compared every clock
  initial begin
    logic [7:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      if (smp_valid) begin
        smp_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R4 sample with nothing fetched", smp_data, 0);
        else begin
          e = exp_q.pop_front();
          chk(smp_data == e, "R4 sample order and value", smp_data, e);
        end
        if (last_ok) chk(((cyc - last_cyc) % SC) == 0 && cyc > last_cyc,
                         "R4 strobe spacing", cyc - last_cyc, SC);
        last_cyc = cyc;
        last_ok = 1'b1;
      end
      if (rst_n && stat[0] && !prev_irq)
        chk(exp_q.size() >= 1 && exp_q.size() <= DEPTH, "R9 bytes in flight at interrupt",
            exp_q.size(), DEPTH);
      prev_irq = stat[0];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int r0, s0, n;
    repeat (3) @(negedge clk);
    chk(stat == 2'b00, "R1 status after reset", stat, 0);
    chk(!mem_req, "R1 no request in reset", mem_req, 0);
    chk(!smp_valid, "R1 no strobe in reset", smp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: wrong burst size does not start the engine
    wr(3'd1, 32'h100); wr(3'd2, 32'h140);
    wr(3'd0, 32'h28);
    r0 = req_cnt;
    repeat (60) @(negedge clk);
    chk(req_cnt == r0, "R2 size 8 leaves engine idle", req_cnt, r0);

    // R5: A then valid B
    wr(3'd3, 32'h400); wr(3'd4, 32'h440);
    wr(3'd0, 32'h30);
    wait_stat(2'b01, "R5 interrupt at end of A with B valid");
    // R6: B drains with no valid A
    wait_stat(2'b11, "R6 overrun when A is not valid");
    wait_drain();
    chk(smp_cnt == 128, "R4 every fetched byte played", smp_cnt, 128);
    r0 = req_cnt;
    repeat (100) @(negedge clk);
    chk(req_cnt == r0, "R6 fetch stalls on invalid buffer", req_cnt, r0);

    // R8: descriptor write drops interrupt, overrun stays
    wr(3'd1, 32'h800);
    chk(stat == 2'b10, "R8 descriptor write clears interrupt", stat, 2'b10);
    wr(3'd2, 32'h820);
    wait_stat(2'b11, "R6 resumed buffer completes");
    chk(req_cnt == r0 + 2, "R6 fetch resumes on refill", req_cnt, r0 + 2);
    wait_drain();

    // R7: stop on B is final, stop on A ignored
    wr(3'd0, 32'h80);
    chk(stat == 2'b00, "R11 clear zeroes flags", stat, 0);
    wr(3'd1, 32'h200); wr(3'd2, 32'h8000_0220);
    wr(3'd3, 32'h300); wr(3'd4, 32'h8000_0320);
    wr(3'd0, 32'h30);
    wait_stat(2'b01, "R7 stop bit on A ignored");
    wr(3'd1, 32'h600); wr(3'd2, 32'h620);
    wait_stat(2'b11, "R7 final B reports both flags");
    wait_drain();
    r0 = req_cnt;
    repeat (200) @(negedge clk);
    chk(req_cnt == r0, "R7 no fetch after final B", req_cnt, r0);

    // R11: clear drops descriptors
    wr(3'd0, 32'h80);
    chk(stat == 2'b00, "R11 clear after completion", stat, 0);
    wr(3'd0, 32'h30);
    r0 = req_cnt;
    repeat (100) @(negedge clk);
    chk(req_cnt == r0, "R11 descriptors invalid after clear", req_cnt, r0);

    // R10: disable mid-buffer
    wr(3'd1, 32'h100); wr(3'd2, 32'h200);
    s0 = smp_cnt;
    n = 0;
    while (smp_cnt < s0 + 10 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(smp_cnt >= s0 + 10, "R10 engine running before disable", smp_cnt, s0 + 10);
    wr(3'd0, 32'h10);
    s0 = smp_cnt;
    r0 = req_cnt;
    repeat (200) @(negedge clk);
    chk(smp_cnt == s0, "R10 no strobe after disable", smp_cnt, s0);
    chk(req_cnt == r0, "R10 no fetch after disable", req_cnt, r0);
    exp_q.delete();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule